// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between the interrupt pins of a chip, a few on-chip interrupt sources and one processor core. Twelve external request lines and one machine-check line arrive with no relation to the clock. Each one is resynchronised first. Each external line then has its own active level, its own choice of level or edge detection, and its own mask bit. Software sets these through a small write-only register port. The port also carries an end-of-interrupt command and a message register.

In normal mode the block keeps one pending bit per external line. It hands the lowest-numbered unmasked pending line, with its index, to the core. In pass-through mode there is no arbitration. Line 0 alone drives the core request. A separate interrupt-out pin shows the OR of the on-chip sources, the active external lines and a nonzero message register, each with a fixed latency. The machine-check input is edge detected. Depending on an enable bit, an edge becomes either a one-cycle machine-check request or a checkstop flag that stays set until reset.

Register port: address 0 polarity, 1 sense, 2 mask, 3 control, 4 message, 5 end-of-interrupt.

Top module: `ext_irq_cond`

## Requirements
- R1: Every external line and the machine-check line passes through a two-flop synchronizer. An external line change that is set up before clock edge 1 shows at the core outputs after edge 4, and not after edge 3.
- R2: Bit i of the polarity register (address 0) selects the active level of line i: 0 means active-high and 1 means active-low.
- R3: With sense bit i at 0 (address 1, level), line i is pending only while it is at its active level. When the line goes inactive, its pending state drops 4 edges later and nothing is latched.
- R4: With sense bit i at 1 (edge), an inactive-to-active transition sets a sticky pending bit. A write to address 5 whose low data bits hold index i clears that bit, and the core request updates after the next edge. The same write aimed at a line in level sense has no effect.
- R5: In normal mode, mask bit i (address 2, 1 = masked) blocks line i. The lowest-numbered unmasked pending line drives core_irq_o=1, with its index on core_idx_o.
- R6: Control bit 0 (address 3) selects pass-through mode. In this mode core_irq_o follows the active level of line 0 with the R1 latency and core_idx_o is 0. Mask and sense do not apply, and lines 1 to 11 never reach the core.
- R7: In pass-through mode, irq_out_o asserts and negates 2 edges after any on-chip source changes, and 4 edges after any external line changes its active state. In normal mode irq_out_o stays 0.
- R8: In pass-through mode, a nonzero write to the message register (address 4) raises irq_out_o one edge after the write edge (2 cycles). A write of zero lowers it with the same delay.
- R9: A rising edge on mchk_i, even one lasting a single clock, gives a one-cycle mchk_req_o pulse after edge 3 when control bit 1 is 1.
- R10: With control bit 1 at 0, the same edge sets checkstop_o. The flag stays set until reset, even if control bit 1 is written to 1 later.
- R11: At reset all lines are masked, active-high and level-sensed. Pass-through mode and machine-check enable are off, and all outputs, the message register and the pending state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 12 | Asynchronous external interrupt lines |
| mchk_i | input | 1 | Asynchronous machine-check line, active high |
| int_src_i | input | 4 | Synchronous on-chip interrupt sources |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 12 | Register write data |
| core_irq_o | output | 1 | Interrupt request to the core (valid flag) |
| core_idx_o | output | 4 | Index of the line behind core_irq_o |
| irq_out_o | output | 1 | Interrupt-out pin |
| mchk_req_o | output | 1 | One-cycle machine-check request |
| checkstop_o | output | 1 | Sticky checkstop request |

## Verification
The hardest state to reach from the ports combines an edge-sensed line whose pending bit is sticky while its input is already low with a level-sensed line that is still asserted and outranks it. An end-of-interrupt write aimed at the level line must leave both lines in place. The stimulus pulses line 9 in edge mode and holds line 3 high at the same time, then sends an end-of-interrupt to line 3, then releases line 3. After that, line 9 must take over at exactly the fourth edge, and only its own end-of-interrupt may clear it. The exact latencies of the interrupt-out pin are checked one edge early and on the edge itself, for internal, external and message sources, in both directions.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  typedef enum logic [2:0] {
    REG_POL   = 3'd0,
    REG_SENSE = 3'd1,
    REG_MASK  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_MSG   = 3'd4,
    REG_EOI   = 3'd5
  } cfg_reg_e;

  localparam int CTRL_PT_BIT  = 0;
  localparam int CTRL_MCE_BIT = 1;

  function automatic logic reg_hit(input logic we, input logic [2:0] addr, input cfg_reg_e which);
    return we && (addr == which);
  endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic eoi_i,
  output logic act_q_o,
  output logic pend_o
);

  logic act;
  logic act_q;
  logic hit;
  logic pend_q;

  assign act = sync_i ^ pol_i;
  assign hit = act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      act_q <= act;
      if (edge_i) pend_q <= (pend_q & ~eoi_i) | hit;
      else        pend_q <= act;
    end
  end

  assign act_q_o = act_q;
  assign pend_o  = pend_q;

  // R3: in level sense the pending state tracks the sampled active level
  a_r3_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && $past(!edge_i)) |-> (pend_q == act_q));

  // R4: an edge-pending bit survives until an end-of-interrupt
  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pend_q && !eoi_i) |=> pend_q);

  // R4: end-of-interrupt clears when no new edge coincides
  a_r4_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && eoi_i && act_q && sync_i == $past(sync_i)) |=> !pend_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  function automatic logic [IW:0] lowest(input logic [N-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IW'(i)};
    end
    return r;
  endfunction

  logic [IW:0] pick;

  assign pick    = lowest(req_i);
  assign found_o = pick[IW];
  assign idx_o   = pick[IW-1:0];

endmodule

// File: rtl/irq_mchk_edge.sv
module irq_mchk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic mchk_s_i,
  input  logic mce_i,
  output logic req_o,
  output logic stop_o
);

  logic prev_q;
  logic rise;
  logic req_q;
  logic stop_q;

  assign rise = mchk_s_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      prev_q <= mchk_s_i;
      req_q  <= rise & mce_i;
      stop_q <= stop_q | (rise & ~mce_i);
    end
  end

  assign req_o  = req_q;
  assign stop_o = stop_q;

  // R9: a request is a single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  // R10: checkstop never clears without reset
  a_r10_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> stop_q);

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import irq_cond_pkg::*;
#(
  parameter int N_EXT = 12,
  parameter int N_INT = 4,
  parameter int MSG_W = 8,
  localparam int IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic             mchk_i,
  input  logic [N_INT-1:0] int_src_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [N_EXT-1:0] cfg_wdata_i,
  output logic             core_irq_o,
  output logic [IDX_W-1:0] core_idx_o,
  output logic             irq_out_o,
  output logic             mchk_req_o,
  output logic             checkstop_o
);

  logic [N_EXT-1:0] pol_q, sense_q, mask_q;
  logic             pt_q, mce_q;
  logic [MSG_W-1:0] msg_q;
  logic [N_INT-1:0] int_q;

  logic [N_EXT:0]   sync_all;
  logic [N_EXT-1:0] ext_s;
  logic             mchk_s;
  logic [N_EXT-1:0] eoi_vec;
  logic [N_EXT-1:0] act_q;
  logic [N_EXT-1:0] pend;
  logic [N_EXT-1:0] eligible;
  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic             out_src;

  logic             core_irq_q;
  logic [IDX_W-1:0] core_idx_q;
  logic             irq_out_q;

  // register port
  logic wr_pol, wr_sense, wr_mask, wr_ctrl, wr_msg, wr_eoi;
  assign wr_pol   = reg_hit(cfg_we_i, cfg_addr_i, REG_POL);
  assign wr_sense = reg_hit(cfg_we_i, cfg_addr_i, REG_SENSE);
  assign wr_mask  = reg_hit(cfg_we_i, cfg_addr_i, REG_MASK);
  assign wr_ctrl  = reg_hit(cfg_we_i, cfg_addr_i, REG_CTRL);
  assign wr_msg   = reg_hit(cfg_we_i, cfg_addr_i, REG_MSG);
  assign wr_eoi   = reg_hit(cfg_we_i, cfg_addr_i, REG_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      sense_q <= '0;
      mask_q  <= '1;
      pt_q    <= 1'b0;
      mce_q   <= 1'b0;
      msg_q   <= '0;
    end else begin
      if (wr_pol)   pol_q   <= cfg_wdata_i;
      if (wr_sense) sense_q <= cfg_wdata_i;
      if (wr_mask)  mask_q  <= cfg_wdata_i;
      if (wr_ctrl) begin
        pt_q  <= cfg_wdata_i[CTRL_PT_BIT];
        mce_q <= cfg_wdata_i[CTRL_MCE_BIT];
      end
      if (wr_msg)   msg_q   <= cfg_wdata_i[MSG_W-1:0];
    end
  end

  always_comb begin
    eoi_vec = '0;
    for (int i = 0; i < N_EXT; i++) begin
      if (wr_eoi && cfg_wdata_i[IDX_W-1:0] == IDX_W'(i)) eoi_vec[i] = 1'b1;
    end
  end

  // synchronizers for all asynchronous inputs
  irq_sync2 #(.W(N_EXT + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({mchk_i, ext_req_i}),
    .q_o   (sync_all)
  );
  assign ext_s  = sync_all[N_EXT-1:0];
  assign mchk_s = sync_all[N_EXT];

  // per-line conditioning
  for (genvar g = 0; g < N_EXT; g++) begin : g_line
    irq_line_cond u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (ext_s[g]),
      .pol_i   (pol_q[g]),
      .edge_i  (sense_q[g]),
      .eoi_i   (eoi_vec[g]),
      .act_q_o (act_q[g]),
      .pend_o  (pend[g])
    );
  end

  assign eligible = pend & ~mask_q;

  irq_prio_pick #(.N(N_EXT)) u_pick (
    .req_i   (eligible),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  // interrupt-out source: internal stage 1 + out stage, external via act_q
  assign out_src = (|int_q) | (|msg_q) | (|act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q      <= '0;
      core_irq_q <= 1'b0;
      core_idx_q <= '0;
      irq_out_q  <= 1'b0;
    end else begin
      int_q     <= int_src_i;
      irq_out_q <= pt_q & out_src;
      if (pt_q) begin
        core_irq_q <= act_q[0];
        core_idx_q <= '0;
      end else begin
        core_irq_q <= win_found;
        core_idx_q <= win_idx;
      end
    end
  end

  assign core_irq_o = core_irq_q;
  assign core_idx_o = core_idx_q;
  assign irq_out_o  = irq_out_q;

  irq_mchk_edge u_mchk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mchk_s_i (mchk_s),
    .mce_i    (mce_q),
    .req_o    (mchk_req_o),
    .stop_o   (checkstop_o)
  );

  // R5: with every line masked in normal mode no request reaches the core
  a_r5_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!pt_q) && (&$past(mask_q))) |-> !core_irq_o);

  // R6: pass-through requests always name line 0
  a_r6_pt_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq_o && $past(pt_q)) |-> (core_idx_o == '0));

  // R7: the interrupt-out pin is silent in normal mode
  a_r7_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pt_q) |-> !irq_out_o);

  // R5: a reported index is always in range
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq_o |-> (int'(core_idx_o) < N_EXT));

endmodule

// File: tb/test_ext_irq_cond.sv
`timescale 1ns/1ps
module test_ext_irq_cond;

  localparam int N_EXT = 12;
  localparam int N_INT = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_EXT-1:0] ext_req = '0;
  logic             mchk = 1'b0;
  logic [N_INT-1:0] int_src = '0;
  logic             we = 1'b0;
  logic [2:0]       addr = '0;
  logic [N_EXT-1:0] wdata = '0;
  logic             core_irq;
  logic [3:0]       core_idx;
  logic             irq_out;
  logic             mchk_req;
  logic             checkstop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_cond i_ext_irq_cond (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_req_i   (ext_req),
    .mchk_i      (mchk),
    .int_src_i   (int_src),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .core_irq_o  (core_irq),
    .core_idx_o  (core_idx),
    .irq_out_o   (irq_out),
    .mchk_req_o  (mchk_req),
    .checkstop_o (checkstop)
  );

  localparam logic [2:0] A_POL = 3'd0, A_SENSE = 3'd1, A_MASK = 3'd2,
                         A_CTRL = 3'd3, A_MSG = 3'd4, A_EOI = 3'd5;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N_EXT-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edges(2);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic mchk_pulse();
    @(negedge clk); mchk = 1'b1;
    @(negedge clk); mchk = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 core_irq", core_irq, 0);
    chk("R11 irq_out", irq_out, 0);
    chk("R11 mchk_req", mchk_req, 0);
    chk("R11 checkstop", checkstop, 0);
    @(negedge clk); ext_req[3] = 1'b1;
    edges(6);
    chk("R11 masked at reset", core_irq, 0);
    @(negedge clk); ext_req[3] = 1'b0;
    edges(6);
  endtask

  task automatic t_level();
    wr(A_MASK, '0);
    @(negedge clk); ext_req[5] = 1'b1;
    edges(3);
    chk("R1 not yet at edge 3", core_irq, 0);
    edges(1);
    chk("R1 level at edge 4", core_irq, 1);
    chk("R1 index", core_idx, 5);
    @(negedge clk); ext_req[5] = 1'b0;
    edges(3);
    chk("R3 held before edge 4", core_irq, 1);
    edges(1);
    chk("R3 no latch", core_irq, 0);
  endtask

  task automatic t_priority();
    @(negedge clk); ext_req[7] = 1'b1; ext_req[2] = 1'b1;
    edges(5);
    chk("R5 lowest wins flag", core_irq, 1);
    chk("R5 lowest wins idx", core_idx, 2);
    wr(A_MASK, 12'h004);
    edges(1);
    chk("R5 mask skips line 2", core_idx, 7);
    wr(A_MASK, 12'h084);
    edges(1);
    chk("R5 both masked", core_irq, 0);
    wr(A_MASK, '0);
    @(negedge clk); ext_req[7] = 1'b0; ext_req[2] = 1'b0;
    edges(6);
  endtask

  task automatic t_polarity();
    wr(A_POL, 12'h010);
    edges(4);
    chk("R2 active-low idle line pending", core_irq, 1);
    chk("R2 index", core_idx, 4);
    @(negedge clk); ext_req[4] = 1'b1;
    edges(4);
    chk("R2 high is inactive", core_irq, 0);
    wr(A_POL, '0);
    @(negedge clk); ext_req[4] = 1'b0;
    edges(6);
    chk("R2 restored", core_irq, 0);
  endtask

  task automatic t_edge();
    wr(A_SENSE, 12'h200);
    @(negedge clk); ext_req[9] = 1'b1; ext_req[3] = 1'b1;
    @(negedge clk); ext_req[9] = 1'b0;
    edges(6);
    chk("R4 level 3 outranks", core_idx, 3);
    wr(A_EOI, 12'd3);
    edges(2);
    chk("R4 eoi on level line no effect", core_irq, 1);
    chk("R4 eoi on level line idx", core_idx, 3);
    @(negedge clk); ext_req[3] = 1'b0;
    edges(4);
    chk("R4 sticky edge shows", core_irq, 1);
    chk("R4 sticky edge idx", core_idx, 9);
    wr(A_EOI, 12'd9);
    edges(1);
    chk("R4 eoi clears", core_irq, 0);
    edges(6);
    chk("R4 stays clear", core_irq, 0);
    wr(A_SENSE, '0);
  endtask

  task automatic t_passthrough();
    wr(A_CTRL, 12'h001);
    @(negedge clk); ext_req[1] = 1'b1;
    edges(3);
    chk("R7 ext assert not at edge 3", irq_out, 0);
    edges(1);
    chk("R7 ext assert edge 4", irq_out, 1);
    chk("R6 line 1 not to core", core_irq, 0);
    @(negedge clk); ext_req[0] = 1'b1;
    edges(4);
    chk("R6 line 0 to core", core_irq, 1);
    chk("R6 index zero", core_idx, 0);
    wr(A_MASK, '1);
    edges(2);
    chk("R6 mask ignored", core_irq, 1);
    @(negedge clk); ext_req[0] = 1'b0;
    edges(4);
    chk("R6 follows line 0 low", core_irq, 0);
    @(negedge clk); ext_req[1] = 1'b0;
    edges(3);
    chk("R7 ext negate not at edge 3", irq_out, 1);
    edges(1);
    chk("R7 ext negate edge 4", irq_out, 0);
    @(negedge clk); int_src[2] = 1'b1;
    edges(1);
    chk("R7 int assert not at edge 1", irq_out, 0);
    edges(1);
    chk("R7 int assert edge 2", irq_out, 1);
    @(negedge clk); int_src[2] = 1'b0;
    edges(1);
    chk("R7 int negate not at edge 1", irq_out, 1);
    edges(1);
    chk("R7 int negate edge 2", irq_out, 0);
  endtask

  task automatic t_message();
    wr(A_MSG, 12'h05a);
    chk("R8 msg not yet", irq_out, 0);
    edges(1);
    chk("R8 msg asserts", irq_out, 1);
    wr(A_MSG, '0);
    chk("R8 msg clear not yet", irq_out, 1);
    edges(1);
    chk("R8 msg clear negates", irq_out, 0);
  endtask

  task automatic t_quiet();
    wr(A_CTRL, '0);
    @(negedge clk); int_src = 4'hf; ext_req[1] = 1'b1;
    wr(A_MSG, 12'h001);
    edges(6);
    chk("R7 normal mode irq_out low", irq_out, 0);
    @(negedge clk); int_src = '0; ext_req[1] = 1'b0;
    wr(A_MSG, '0);
    edges(6);
  endtask

  task automatic t_mchk();
    wr(A_CTRL, 12'h002);
    mchk_pulse();
    edges(1);
    chk("R9 not at edge 2", mchk_req, 0);
    edges(1);
    chk("R9 request at edge 3", mchk_req, 1);
    edges(1);
    chk("R9 one cycle", mchk_req, 0);
    chk("R9 no checkstop", checkstop, 0);
  endtask

  task automatic t_checkstop();
    wr(A_CTRL, '0);
    mchk_pulse();
    edges(1);
    chk("R10 not at edge 2", checkstop, 0);
    edges(1);
    chk("R10 checkstop at edge 3", checkstop, 1);
    chk("R10 no request", mchk_req, 0);
    edges(10);
    chk("R10 sticky", checkstop, 1);
    wr(A_CTRL, 12'h002);
    edges(2);
    chk("R10 enable does not clear", checkstop, 1);
    do_reset();
    #1;
    chk("R11 reset clears checkstop", checkstop, 0);
    @(negedge clk); ext_req[3] = 1'b1;
    edges(6);
    chk("R11 mask restored", core_irq, 0);
    @(negedge clk); ext_req[3] = 1'b0;
  endtask

  initial begin
    do_reset();
    #1;
    t_reset();
    t_level();
    t_priority();
    t_polarity();
    t_edge();
    t_passthrough();
    t_message();
    t_quiet();
    t_mchk();
    t_checkstop();
    edges(4);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule